// File: doc/BRIEF.md
# Switch Memory Request Router

This block makes the routing decision for a memory request that enters a switch. A request carries a 64-bit address and the index of the port it came in on. The block compares the address with the memory windows set up for every port and with the address ranges claimed by the switch's own internal functions. It returns one result per request: a one-hot egress port, a hit on an internal function range, or an unsupported-request flag.

Port 0 is the upstream port. Ports 1 to N_PORTS-1 are downstream ports. Each port has two windows:
- a window below 4 GB, set in 1 MB steps;
- a 64-bit prefetchable window, also set in 1 MB steps, built from a low register and a high register.

Each internal range has a 64-bit base and a 64-bit limit, both counted in bytes. Software loads all of these through a plain register write port.

Requests arrive on a valid/ready channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The decision appears on a registered valid/ready output one cycle after acceptance.

Back-pressure works as follows:
- `req_ready` is high whenever the output stage is empty, or whenever the output stage is being drained in the same cycle (`dec_ready` high).
- While `dec_valid` is high and `dec_ready` is low, every output holds its value.

The decision uses the configuration registers as they stand at the accepting edge. A write on that same edge is not seen by the request.

Top module: `mrr_router`

## Requirements
- R1: After reset, `dec_valid` is low and `req_ready` is high. Every window and every internal range starts disabled, so any address is sent to the upstream port.
- R2: A write takes effect when `cfg_we` is high at a clock edge. The register is chosen as follows:
  - With `cfg_bar`=0, `cfg_idx` selects a port, and `cfg_reg` picks the field: 0 low-window base, 1 low-window limit, 2 prefetchable base low, 3 prefetchable limit low, 4 prefetchable base high, 5 prefetchable limit high.
  - With `cfg_bar`=1, `cfg_idx` selects an internal range, and `cfg_reg` picks the field: 0 base bits 31:0, 1 base bits 63:32, 2 limit bits 31:0, 3 limit bits 63:32.
  - For port codes 0 to 3, the 1 MB field is taken from `cfg_wdata[31:20]`.
  - Port codes 4 and 5 take all 32 bits as address bits 63:32.
- R3: The low window matches only when address bits 63:32 are zero and base <= address[31:20] <= limit. The limit therefore covers its whole 1 MB region.
- R4: The prefetchable window matches when base <= address[63:20] <= limit. Both base and limit are 44-bit values: the high register supplies bits 63:32 and the low register supplies bits 31:20.
- R5: A window whose base is greater than its limit never matches. The same holds for an internal range whose base is greater than its limit.
- R6: If one or more downstream ports other than the ingress port have a matching window, the lowest-numbered of them is the only bit set in `dec_egress`.
- R7: The ingress port's own windows never take part in the downstream match.
- R8: Internal ranges are checked only when no downstream port matched. On a hit, `dec_internal` is high and `dec_bar` is one-hot on the lowest-numbered matching range.
- R9: The upstream port's windows are checked only when neither a downstream window nor an internal range matched. A match there sets `dec_unsup`.
- R10: An address that matches nothing is sent upstream, with `dec_egress` = bit 0 only.
- R11: With `dec_valid` high, exactly one of these is true: a single `dec_egress` bit, `dec_internal`, or `dec_unsup`.
- R12: A request accepted at edge k gives `dec_valid` high after edge k. While `dec_valid` is high and `dec_ready` is low, the outputs hold their values. Results leave in the order the requests were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_bar | input | 1 | 0 = port window register, 1 = internal range register |
| cfg_idx | input | IW | Port or internal range index |
| cfg_reg | input | 3 | Field select |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_addr | input | 64 | Request address |
| req_port | input | PW | Ingress port index |
| dec_valid | output | 1 | Decision valid |
| dec_ready | input | 1 | Consumer ready for the decision |
| dec_egress | output | N_PORTS | One-hot egress port |
| dec_internal | output | 1 | Internal function range hit |
| dec_bar | output | N_BARS | One-hot internal range that hit |
| dec_unsup | output | 1 | Unsupported request |

## Verification
The bench targets the edges of the 1 MB regions:
- the first byte of a window's base region;
- the last byte of its limit region.

A design that compared the limit without its low 20 bits would drop the top of each window.

The bench also targets priority conflicts:
- a peer window overlapping an internal range;
- two peer windows overlapping each other;
- a request whose own ingress window holds the address.

Getting any of these wrong sends the request to the wrong egress, or reflects it back out of the port it came in on.

Three further corner cases are covered:
- An address with nonzero upper bits that would hit a low window if those bits were ignored.
- A window that is disabled by setting its base above its limit.
- A stalled output that is held for several cycles, where a faulty pipeline would lose or reorder decisions.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

  // Port window set: low window in 1 MB units, prefetchable window as address[63:20]
  typedef struct packed {
    logic [11:0] lo_base;
    logic [11:0] lo_limit;
    logic [43:0] pf_base;
    logic [43:0] pf_limit;
  } win_t;

  // Internal function range, byte granular, inclusive
  typedef struct packed {
    logic [63:0] base;
    logic [63:0] limit;
  } brange_t;

  // Port field select codes
  localparam logic [2:0] SEL_LO_BASE    = 3'd0;
  localparam logic [2:0] SEL_LO_LIMIT   = 3'd1;
  localparam logic [2:0] SEL_PF_BASE_L  = 3'd2;
  localparam logic [2:0] SEL_PF_LIMIT_L = 3'd3;
  localparam logic [2:0] SEL_PF_BASE_H  = 3'd4;
  localparam logic [2:0] SEL_PF_LIMIT_H = 3'd5;

  // Internal range field select codes
  localparam logic [2:0] SEL_RB_BASE_L  = 3'd0;
  localparam logic [2:0] SEL_RB_BASE_H  = 3'd1;
  localparam logic [2:0] SEL_RB_LIMIT_L = 3'd2;
  localparam logic [2:0] SEL_RB_LIMIT_H = 3'd3;

  // Disabled reset values: base above limit
  localparam win_t WIN_OFF = '{lo_base: '1, lo_limit: '0, pf_base: '1, pf_limit: '0};
  localparam brange_t RANGE_OFF = '{base: '1, limit: '0};

endpackage

// File: rtl/mrr_cfg_regs.sv
module mrr_cfg_regs
  import mrr_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int N_BARS  = 2,
  parameter int IW      = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic                      cfg_bar,
  input  logic [IW-1:0]             cfg_idx,
  input  logic [2:0]                cfg_reg,
  input  logic [31:0]               cfg_wdata,
  output win_t    [N_PORTS-1:0]     wins,
  output brange_t [N_BARS-1:0]      ranges
);

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic sel_port;
    assign sel_port = cfg_we && !cfg_bar && (cfg_idx == IW'(p));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wins[p] <= WIN_OFF;
      end else if (sel_port) begin
        case (cfg_reg)
          SEL_LO_BASE:    wins[p].lo_base         <= cfg_wdata[31:20];
          SEL_LO_LIMIT:   wins[p].lo_limit        <= cfg_wdata[31:20];
          SEL_PF_BASE_L:  wins[p].pf_base[11:0]   <= cfg_wdata[31:20];
          SEL_PF_LIMIT_L: wins[p].pf_limit[11:0]  <= cfg_wdata[31:20];
          SEL_PF_BASE_H:  wins[p].pf_base[43:12]  <= cfg_wdata;
          SEL_PF_LIMIT_H: wins[p].pf_limit[43:12] <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  for (genvar b = 0; b < N_BARS; b++) begin : g_range
    logic sel_rng;
    assign sel_rng = cfg_we && cfg_bar && (cfg_idx == IW'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ranges[b] <= RANGE_OFF;
      end else if (sel_rng) begin
        case (cfg_reg)
          SEL_RB_BASE_L:  ranges[b].base[31:0]   <= cfg_wdata;
          SEL_RB_BASE_H:  ranges[b].base[63:32]  <= cfg_wdata;
          SEL_RB_LIMIT_L: ranges[b].limit[31:0]  <= cfg_wdata;
          SEL_RB_LIMIT_H: ranges[b].limit[63:32] <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mrr_win_match.sv
module mrr_win_match
  import mrr_pkg::*;
(
  input  win_t        win,
  input  logic [43:0] blk,   // address[63:20]
  output logic        hit
);

  logic lo_en, pf_en, lo_hit, pf_hit;

  always_comb begin
    lo_en  = win.lo_base <= win.lo_limit;
    pf_en  = win.pf_base <= win.pf_limit;
    lo_hit = lo_en && (blk[43:12] == 32'd0) &&
             (blk[11:0] >= win.lo_base) && (blk[11:0] <= win.lo_limit);
    pf_hit = pf_en && (blk >= win.pf_base) && (blk <= win.pf_limit);
    hit    = lo_hit || pf_hit;
  end

endmodule

// File: rtl/mrr_range_match.sv
module mrr_range_match
  import mrr_pkg::*;
(
  input  brange_t     rng,
  input  logic [63:0] addr,
  output logic        hit
);

  always_comb begin
    hit = (rng.base <= rng.limit) && (addr >= rng.base) && (addr <= rng.limit);
  end

endmodule

// File: rtl/mrr_router.sv
module mrr_router
  import mrr_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int N_BARS  = 2,
  localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int BW = (N_BARS > 1) ? $clog2(N_BARS) : 1,
  localparam int IW = (PW > BW) ? PW : BW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_bar,
  input  logic [IW-1:0]       cfg_idx,
  input  logic [2:0]          cfg_reg,
  input  logic [31:0]         cfg_wdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [63:0]         req_addr,
  input  logic [PW-1:0]       req_port,
  output logic                dec_valid,
  input  logic                dec_ready,
  output logic [N_PORTS-1:0]  dec_egress,
  output logic                dec_internal,
  output logic [N_BARS-1:0]   dec_bar,
  output logic                dec_unsup
);

  win_t    [N_PORTS-1:0] wins;
  brange_t [N_BARS-1:0]  ranges;

  mrr_cfg_regs #(.N_PORTS(N_PORTS), .N_BARS(N_BARS), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bar(cfg_bar),
    .cfg_idx(cfg_idx), .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata),
    .wins(wins), .ranges(ranges)
  );

  logic [N_PORTS-1:0] win_hit;
  logic [N_BARS-1:0]  rng_hit;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_wm
    mrr_win_match u_wm (.win(wins[p]), .blk(req_addr[63:20]), .hit(win_hit[p]));
  end

  for (genvar b = 0; b < N_BARS; b++) begin : g_rm
    mrr_range_match u_rm (.rng(ranges[b]), .addr(req_addr), .hit(rng_hit[b]));
  end

  // Priority decode: peer downstream, internal range, upstream window, default upstream
  logic [N_PORTS-1:0] peer_hit, peer_sel, nx_egress;
  logic [N_BARS-1:0]  rng_sel, nx_bar;
  logic               nx_internal, nx_unsup;

  always_comb begin
    peer_hit    = win_hit & ~(N_PORTS'(1) << req_port) & ~N_PORTS'(1);
    peer_sel    = peer_hit & (~peer_hit + N_PORTS'(1));
    rng_sel     = rng_hit & (~rng_hit + N_BARS'(1));
    nx_egress   = '0;
    nx_bar      = '0;
    nx_internal = 1'b0;
    nx_unsup    = 1'b0;
    if (peer_hit != '0) begin
      nx_egress = peer_sel;
    end else if (rng_hit != '0) begin
      nx_internal = 1'b1;
      nx_bar      = rng_sel;
    end else if (win_hit[0]) begin
      nx_unsup = 1'b1;
    end else begin
      nx_egress = N_PORTS'(1);
    end
  end

  // Output register stage
  logic          accept;
  logic [PW-1:0] out_port;

  assign req_ready = !dec_valid || dec_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid    <= 1'b0;
      dec_egress   <= '0;
      dec_internal <= 1'b0;
      dec_bar      <= '0;
      dec_unsup    <= 1'b0;
      out_port     <= '0;
    end else if (accept) begin
      dec_valid    <= 1'b1;
      dec_egress   <= nx_egress;
      dec_internal <= nx_internal;
      dec_bar      <= nx_bar;
      dec_unsup    <= nx_unsup;
      out_port     <= req_port;
    end else if (dec_ready) begin
      dec_valid    <= 1'b0;
    end
  end

  // R12
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> dec_valid);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=>
      (dec_valid && $stable(dec_egress) && $stable(dec_internal) &&
       $stable(dec_bar) && $stable(dec_unsup)));

  // R11
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ($countones({dec_egress, dec_internal, dec_unsup}) == 1));

  // R7
  no_reflect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && out_port != '0) |-> !dec_egress[out_port]);

  // R8
  range_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ($onehot0(dec_bar) && (dec_internal == (dec_bar != '0))));

endmodule

// File: tb/tb_mrr_router.sv
module tb_mrr_router;

  localparam int NP = 4;
  localparam int NB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_bar = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [2:0]  cfg_reg = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic [1:0]  req_port = '0;
  logic        dec_valid;
  logic        dec_ready = 1'b1;
  logic [NP-1:0] dec_egress;
  logic        dec_internal;
  logic [NB-1:0] dec_bar;
  logic        dec_unsup;

  always #10 clk = ~clk;   // 50 MHz

  mrr_router #(.N_PORTS(NP), .N_BARS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bar(cfg_bar),
    .cfg_idx(cfg_idx), .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_port(req_port), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_egress(dec_egress), .dec_internal(dec_internal), .dec_bar(dec_bar),
    .dec_unsup(dec_unsup)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Shadow of configuration, kept by the bench from the write encoding
  logic [11:0] s_lob [NP];
  logic [11:0] s_lol [NP];
  logic [43:0] s_pfb [NP];
  logic [43:0] s_pfl [NP];
  logic [63:0] s_rb  [NB];
  logic [63:0] s_rl  [NB];

  logic [7:0] exp_q [$];
  string      tag_q [$];

  initial begin
    for (int i = 0; i < NP; i++) begin
      s_lob[i] = '1; s_lol[i] = '0; s_pfb[i] = '1; s_pfl[i] = '0;
    end
    for (int i = 0; i < NB; i++) begin
      s_rb[i] = '1; s_rl[i] = '0;
    end
  end

  function automatic logic win_hit(int p, logic [63:0] a);
    logic lo, pf;
    lo = (s_lob[p] <= s_lol[p]) && (a[63:32] == 0) &&
         (a[31:20] >= s_lob[p]) && (a[31:20] <= s_lol[p]);
    pf = (s_pfb[p] <= s_pfl[p]) && (a[63:20] >= s_pfb[p]) && (a[63:20] <= s_pfl[p]);
    return lo || pf;
  endfunction

  // Result packing: {egress[3:0], internal, bar[1:0], unsup}
  function automatic logic [7:0] model(logic [63:0] a, int ip);
    for (int p = 1; p < NP; p++)
      if (p != ip && win_hit(p, a)) return {4'(1 << p), 1'b0, 2'b00, 1'b0};
    for (int b = 0; b < NB; b++)
      if (s_rb[b] <= s_rl[b] && a >= s_rb[b] && a <= s_rl[b])
        return {4'b0000, 1'b1, 2'(1 << b), 1'b0};
    if (win_hit(0, a)) return {4'b0000, 1'b0, 2'b00, 1'b1};
    return {4'b0001, 1'b0, 2'b00, 1'b0};
  endfunction

  task automatic cfg_w(input logic bar, input int idx, input logic [2:0] sel,
                       input logic [31:0] d);
    cfg_we = 1'b1; cfg_bar = bar; cfg_idx = 2'(idx); cfg_reg = sel; cfg_wdata = d;
    if (!bar) begin
      case (sel)
        3'd0: s_lob[idx] = d[31:20];
        3'd1: s_lol[idx] = d[31:20];
        3'd2: s_pfb[idx][11:0] = d[31:20];
        3'd3: s_pfl[idx][11:0] = d[31:20];
        3'd4: s_pfb[idx][43:12] = d;
        3'd5: s_pfl[idx][43:12] = d;
        default: ;
      endcase
    end else begin
      case (sel)
        3'd0: s_rb[idx][31:0] = d;
        3'd1: s_rb[idx][63:32] = d;
        3'd2: s_rl[idx][31:0] = d;
        3'd3: s_rl[idx][63:32] = d;
        default: ;
      endcase
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Driver: called just after a negedge, returns at the negedge after acceptance
  task automatic send(input logic [63:0] a, input int ip, input string tag);
    req_addr = a; req_port = 2'(ip); req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    exp_q.push_back(model(a, ip));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor / scoreboard, samples mid low phase
  logic       stall_prev = 1'b0;
  logic [7:0] prev_out = '0;
  logic [7:0] cur_out;
  assign cur_out = {dec_egress, dec_internal, dec_bar, dec_unsup};

  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      if (stall_prev) begin
        n_chk++;
        if (!dec_valid || cur_out !== prev_out) begin
          n_fail++;
          $display("FAIL R12 hold: got v=%0b %h expected v=1 %h", dec_valid, cur_out, prev_out);
        end
      end
      if (dec_valid && dec_ready) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R12 order: got unexpected result %h expected none", cur_out);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (cur_out !== e) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", t, cur_out, e);
          end
        end
      end
      stall_prev = dec_valid && !dec_ready;
      prev_out = cur_out;
    end
  end

  // Back-pressure generator
  logic bp_en = 1'b0;
  int   cyc = 0;
  always @(negedge clk) begin
    cyc++;
    dec_ready = !bp_en || (cyc % 4 == 0);
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R1 reset state
    n_chk++;
    if (dec_valid !== 1'b0 || req_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: got valid=%0b ready=%0b expected valid=0 ready=1", dec_valid, req_ready);
    end
    @(negedge clk);
    send(64'h0000_0000_1234_5678, 1, "R1 disabled default");
    send(64'h0000_0001_0000_0000, 2, "R10 default upper");

    // R2 programming
    cfg_w(0, 1, 3'd0, 32'h1000_0000); cfg_w(0, 1, 3'd1, 32'h1FF0_0000);
    cfg_w(0, 2, 3'd0, 32'h2000_0000); cfg_w(0, 2, 3'd1, 32'h2FF0_0000);
    cfg_w(0, 3, 3'd2, 32'h0000_0000); cfg_w(0, 3, 3'd4, 32'h0000_0001);
    cfg_w(0, 3, 3'd3, 32'hFFF0_0000); cfg_w(0, 3, 3'd5, 32'h0000_0001);
    cfg_w(0, 0, 3'd0, 32'h0800_0000); cfg_w(0, 0, 3'd1, 32'h3FF0_0000);
    cfg_w(1, 0, 3'd0, 32'h3000_0000); cfg_w(1, 0, 3'd1, 32'h0);
    cfg_w(1, 0, 3'd2, 32'h3000_0FFF); cfg_w(1, 0, 3'd3, 32'h0);
    cfg_w(1, 1, 3'd0, 32'h3000_0800); cfg_w(1, 1, 3'd1, 32'h0);
    cfg_w(1, 1, 3'd2, 32'h3000_1FFF); cfg_w(1, 1, 3'd3, 32'h0);

    send(64'h0000_0000_1000_0000, 2, "R3 R6 base edge");
    send(64'h0000_0000_1FFF_FFFF, 2, "R3 limit inclusive");
    send(64'h0000_0000_2000_0000, 1, "R6 peer port2");
    send(64'h0000_0000_2000_0000, 2, "R7 ingress excluded R9");
    send(64'h0000_0000_3000_0900, 1, "R8 overlap lowest range");
    send(64'h0000_0000_3000_1000, 1, "R8 second range");
    send(64'h0000_0000_3000_2000, 1, "R9 upstream window");
    send(64'h0000_0000_0700_0000, 1, "R10 below upstream window");
    send(64'h0000_0000_4000_0000, 1, "R10 above upstream window");
    send(64'h0000_0001_0000_0000, 1, "R4 pf base");
    send(64'h0000_0001_FFFF_FFFF, 1, "R4 pf limit");
    send(64'h0000_0002_0000_0000, 1, "R4 pf beyond");
    send(64'h0000_0005_1000_0000, 2, "R3 upper bits nonzero");

    // R8: peer outranks an overlapping internal range
    cfg_w(1, 1, 3'd0, 32'h1000_0000); cfg_w(1, 1, 3'd2, 32'h1000_FFFF);
    send(64'h0000_0000_1000_0000, 2, "R8 peer over range");
    send(64'h0000_0000_1000_0000, 1, "R8 range when ingress");

    // R6: two peers overlap, lowest index wins
    cfg_w(0, 3, 3'd0, 32'h1000_0000); cfg_w(0, 3, 3'd1, 32'h10F0_0000);
    send(64'h0000_0000_1000_0000, 2, "R6 lowest peer");
    send(64'h0000_0000_1020_0000, 1, "R6 other peer when ingress low");

    // R5: disable port2 window by base above limit
    cfg_w(0, 2, 3'd0, 32'h3000_0000);
    send(64'h0000_0000_2000_0000, 1, "R5 disabled window");

    // R12 latency from idle
    repeat (2) @(negedge clk);
    send(64'h0000_0000_4000_0000, 3, "R12 single");
    #5;
    n_chk++;
    if (dec_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R12 latency: got valid=%0b expected 1", dec_valid);
    end
    @(negedge clk);

    // R12 back-pressure burst
    bp_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      send(64'h0000_0000_1000_0000 + 64'(i) * 64'h0100_0000, (i % 3) + 1, "R12 burst");
    end
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    bp_en = 1'b0;
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R12 drain: got %0d pending expected 0", exp_q.size());
    end
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule